// File: doc/BRIEF.md
# Dual smart card contact controller

This block sits between a host controller and two smart card slots. It carries the reset, the two auxiliary contacts (C4, C8) and the serial data line of each slot. Every contact output is in one of two states. It is transparent, passing the current host value. Or it is held, keeping the value stored on the clock edge at which transparency ended. A chip select, a program strobe and a card-select bit decide which state applies. When a slot's supply is not good, or its supply startup has not finished, all of that slot's contact outputs are clamped to zero and its stored values are cleared.

In split mode each slot has its own host reset and data lines, and both slots can be driven together. In shared mode the second slot's own host lines are ignored. Traffic for either slot then travels over the first slot's host lines, and the card-select bit steers it. The data line is modelled as an open-drain link. Toward the card the block only pulls low. Toward the host it pulls the host line low only when the card pulls low and the host has released the line. The analog parts (level shifting, pull-up resistors, DC/DC conversion) are represented only by per-slot pull-up enable outputs.

Top module: `dual_card_contact_ctrl`

## Requirements
- R1: A slot's RST output follows its reset source only while cs_ni=0 and pgm_ni=1; in shared mode the slot must also be selected. Otherwise RST holds its stored value.
- R2: With mux_mode_i=0, slot k takes its reset from host_rst_i[k] and its data from host_io_i[k]. Its data path is transparent whenever cs_ni=0, and its RST whenever cs_ni=0 and pgm_ni=1, in both cases regardless of card_sel_i.
- R3: With mux_mode_i=1, host_rst_i[1] and host_io_i[1] have no effect. The selected slot uses host_rst_i[0] and host_io_i[0]. The unselected slot's RST and data are held. host_io_o[1] and host_io_oe_o[1] are 0.
- R4: The C4 and C8 outputs of slot k take host_c4_i and host_c8_i only while slot k is selected, cs_ni=0 and pgm_ni=1; otherwise they hold. card_sel_i=1 selects slot 0 and card_sel_i=0 selects slot 1.
- R5: While a slot's data path is transparent, card_io_o[k] equals its data source and card_io_oe_o[k] (1 = pull card line low) is the inverse of that source. While the path is held, card_io_o[k] shows the stored line value and card_io_oe_o[k] is 0.
- R6: Host line j reports the card line (card_io_i) of the slot mapped to it while that slot is transparent, and the stored line value while it is held. host_io_oe_o[j] is 1 only when the slot is transparent, card_io_i is 0 and the host source is 1. Host line 0 maps to the selected slot in shared mode and to slot 0 in split mode. Host line 1 maps to slot 1 in split mode.
- R7: While vcc_good_i[k]=0 or vcc_up_i[k]=0, card_rst_o, card_c4_o, card_c8_o, card_io_o and card_io_oe_o of slot k are 0, and so are the host-side value and enable fed from slot k.
- R8: While a slot's supply is unsafe, its stored values are cleared to 0. After recovery, held outputs read 0.
- R9: A stored value equals the source value in the last cycle of transparency; for data, the stored value is card_io_i in that cycle.
- R10: pu_en_o[0] equals pu_en_i. pu_en_o[1] equals pu_en_i OR mux_mode_i.
- R11: After reset, every stored value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| pgm_ni | input | 1 | Program strobe, active low |
| card_sel_i | input | 1 | 1 selects slot 0, 0 selects slot 1 |
| mux_mode_i | input | 1 | 1 = shared host lines, 0 = split |
| pu_en_i | input | 1 | Pull-up enable request |
| host_rst_i | input | 2 | Host reset line per slot |
| host_io_i | input | 2 | Host data line per slot (1 = released) |
| host_c4_i | input | 1 | Host C4 value |
| host_c8_i | input | 1 | Host C8 value |
| vcc_good_i | input | 2 | Slot supply above threshold |
| vcc_up_i | input | 2 | Slot supply startup finished |
| card_io_i | input | 2 | Level seen on the card data line |
| card_rst_o | output | 2 | Card RST contact |
| card_c4_o | output | 2 | Card C4 contact |
| card_c8_o | output | 2 | Card C8 contact |
| card_io_o | output | 2 | Card data value |
| card_io_oe_o | output | 2 | Pull card data line low |
| host_io_o | output | 2 | Data value returned on each host line |
| host_io_oe_o | output | 2 | Pull host data line low |
| pu_en_o | output | 2 | Per-slot pull-up enable |

## Verification
The hold and clear properties assume that every control, host and card input is stable around the rising clock edge. Storage captures what the inputs present at that edge, and the properties compare one cycle against the next. The assertions do not assume that card_io_i answers the block's own drive. The stimulus therefore changes all inputs only at the falling edge and picks card_io_i independently of the outputs. Phases bias chip select, the program strobe, selection and the supply bits so that long held stretches, supply drops during holds, and mode changes mid-transfer all occur.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
  localparam int unsigned NUM_CARDS = 2;

  typedef struct packed {
    logic rst;
    logic c4;
    logic c8;
    logic io;
  } contact_t;

  typedef struct packed {
    logic rst;
    logic aux;
    logic io;
  } transp_t;

  function automatic logic card_selected(int unsigned idx, logic card_sel);
    return (idx == 0) ? card_sel : ~card_sel;
  endfunction
endpackage

// File: rtl/dcc_route.sv
`timescale 1ns/1ps
module dcc_route
  import dcc_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    pgm_ni,
  input  logic                    card_sel_i,
  input  logic                    mux_mode_i,
  input  logic [NUM_CARDS-1:0]    host_rst_i,
  input  logic [NUM_CARDS-1:0]    host_io_i,
  input  logic                    host_c4_i,
  input  logic                    host_c8_i,
  output contact_t [NUM_CARDS-1:0] src_o,
  output transp_t  [NUM_CARDS-1:0] tr_o
);
  logic xfer;
  logic cs_act;

  assign cs_act = ~cs_ni;
  assign xfer   = cs_act & pgm_ni;

  for (genvar k = 0; k < NUM_CARDS; k++) begin : g_card
    logic sel;
    logic own_line;

    assign sel      = card_selected(k, card_sel_i);
    // split mode: each slot owns its host lines; shared mode: only the selected one
    assign own_line = sel | ~mux_mode_i;

    assign src_o[k].rst = mux_mode_i ? host_rst_i[0] : host_rst_i[k];
    assign src_o[k].io  = mux_mode_i ? host_io_i[0]  : host_io_i[k];
    assign src_o[k].c4  = host_c4_i;
    assign src_o[k].c8  = host_c8_i;

    assign tr_o[k].rst = xfer & own_line;
    assign tr_o[k].aux = xfer & sel;
    assign tr_o[k].io  = cs_act & own_line;
  end

  // R4: auxiliary contacts never transparent on both slots
  p_one_aux_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tr_o[0].aux && tr_o[1].aux));

  // R3: in shared mode at most one data path passes
  p_one_io_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_mode_i |-> !(tr_o[0].io && tr_o[1].io));
endmodule

// File: rtl/dcc_contact.sv
`timescale 1ns/1ps
module dcc_contact
  import dcc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     vcc_good_i,
  input  logic     vcc_up_i,
  input  contact_t src_i,
  input  transp_t  tr_i,
  input  logic     card_io_i,
  output logic     rst_o,
  output logic     c4_o,
  output logic     c8_o,
  output logic     io_o,
  output logic     io_oe_o,
  output logic     ret_val_o,
  output logic     ret_oe_o
);
  logic     safe;
  contact_t held_q;
  contact_t live;

  assign safe = vcc_good_i & vcc_up_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
    end else if (!safe) begin
      held_q <= '0;
    end else begin
      if (tr_i.rst) held_q.rst <= src_i.rst;
      if (tr_i.aux) begin
        held_q.c4 <= src_i.c4;
        held_q.c8 <= src_i.c8;
      end
      if (tr_i.io) held_q.io <= card_io_i;
    end
  end

  always_comb begin
    live.rst = tr_i.rst ? src_i.rst : held_q.rst;
    live.c4  = tr_i.aux ? src_i.c4  : held_q.c4;
    live.c8  = tr_i.aux ? src_i.c8  : held_q.c8;
    live.io  = tr_i.io  ? src_i.io  : held_q.io;
  end

  assign rst_o     = safe & live.rst;
  assign c4_o      = safe & live.c4;
  assign c8_o      = safe & live.c8;
  assign io_o      = safe & live.io;
  assign io_oe_o   = safe & tr_i.io & ~src_i.io;
  assign ret_val_o = safe & (tr_i.io ? card_io_i : held_q.io);
  // return drive only when the card pulls low and the host side is released
  assign ret_oe_o  = safe & tr_i.io & ~card_io_i & src_i.io;

  p_hold_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && safe && $past(safe) && !tr_i.rst) |-> (rst_o == $past(rst_o)));

  p_hold_c4_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && safe && $past(safe) && !tr_i.aux) |-> (c4_o == $past(c4_o)));

  p_hold_c8_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && safe && $past(safe) && !tr_i.aux) |-> (c8_o == $past(c8_o)));

  p_hold_ret_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && safe && $past(safe) && !tr_i.io) |-> (ret_val_o == $past(ret_val_o)));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(safe) && safe) |->
      ((tr_i.rst || !rst_o) && (tr_i.aux || (!c4_o && !c8_o)) && (tr_i.io || !io_o)));
endmodule

// File: rtl/dcc_host_ret.sv
`timescale 1ns/1ps
module dcc_host_ret
  import dcc_pkg::*;
(
  input  logic                 mux_mode_i,
  input  logic                 card_sel_i,
  input  logic [NUM_CARDS-1:0] ret_val_i,
  input  logic [NUM_CARDS-1:0] ret_oe_i,
  output logic [NUM_CARDS-1:0] host_io_o,
  output logic [NUM_CARDS-1:0] host_io_oe_o
);
  for (genvar j = 0; j < NUM_CARDS; j++) begin : g_line
    if (j == 0) begin : g_shared
      logic pick_val;
      logic pick_oe;
      assign pick_val        = card_sel_i ? ret_val_i[0] : ret_val_i[1];
      assign pick_oe         = card_sel_i ? ret_oe_i[0]  : ret_oe_i[1];
      assign host_io_o[j]    = mux_mode_i ? pick_val : ret_val_i[j];
      assign host_io_oe_o[j] = mux_mode_i ? pick_oe  : ret_oe_i[j];
    end else begin : g_own
      assign host_io_o[j]    = ~mux_mode_i & ret_val_i[j];
      assign host_io_oe_o[j] = ~mux_mode_i & ret_oe_i[j];
    end
  end
endmodule

// File: rtl/dual_card_contact_ctrl.sv
`timescale 1ns/1ps
module dual_card_contact_ctrl
  import dcc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 pgm_ni,
  input  logic                 card_sel_i,
  input  logic                 mux_mode_i,
  input  logic                 pu_en_i,
  input  logic [NUM_CARDS-1:0] host_rst_i,
  input  logic [NUM_CARDS-1:0] host_io_i,
  input  logic                 host_c4_i,
  input  logic                 host_c8_i,
  input  logic [NUM_CARDS-1:0] vcc_good_i,
  input  logic [NUM_CARDS-1:0] vcc_up_i,
  input  logic [NUM_CARDS-1:0] card_io_i,
  output logic [NUM_CARDS-1:0] card_rst_o,
  output logic [NUM_CARDS-1:0] card_c4_o,
  output logic [NUM_CARDS-1:0] card_c8_o,
  output logic [NUM_CARDS-1:0] card_io_o,
  output logic [NUM_CARDS-1:0] card_io_oe_o,
  output logic [NUM_CARDS-1:0] host_io_o,
  output logic [NUM_CARDS-1:0] host_io_oe_o,
  output logic [NUM_CARDS-1:0] pu_en_o
);
  contact_t [NUM_CARDS-1:0] src;
  transp_t  [NUM_CARDS-1:0] tr;
  logic     [NUM_CARDS-1:0] ret_val;
  logic     [NUM_CARDS-1:0] ret_oe;

  dcc_route u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .pgm_ni     (pgm_ni),
    .card_sel_i (card_sel_i),
    .mux_mode_i (mux_mode_i),
    .host_rst_i (host_rst_i),
    .host_io_i  (host_io_i),
    .host_c4_i  (host_c4_i),
    .host_c8_i  (host_c8_i),
    .src_o      (src),
    .tr_o       (tr)
  );

  for (genvar k = 0; k < NUM_CARDS; k++) begin : g_slot
    dcc_contact u_contact (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .vcc_good_i (vcc_good_i[k]),
      .vcc_up_i   (vcc_up_i[k]),
      .src_i      (src[k]),
      .tr_i       (tr[k]),
      .card_io_i  (card_io_i[k]),
      .rst_o      (card_rst_o[k]),
      .c4_o       (card_c4_o[k]),
      .c8_o       (card_c8_o[k]),
      .io_o       (card_io_o[k]),
      .io_oe_o    (card_io_oe_o[k]),
      .ret_val_o  (ret_val[k]),
      .ret_oe_o   (ret_oe[k])
    );

    if (k == 0) begin : g_pu_own
      assign pu_en_o[k] = pu_en_i;
    end else begin : g_pu_forced
      assign pu_en_o[k] = pu_en_i | mux_mode_i;
    end

    p_forced_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(vcc_good_i[k] && vcc_up_i[k]) |->
        !(card_rst_o[k] || card_c4_o[k] || card_c8_o[k] || card_io_o[k] || card_io_oe_o[k]));

    p_oe_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      card_io_oe_o[k] |-> !cs_ni);
  end

  dcc_host_ret u_host_ret (
    .mux_mode_i   (mux_mode_i),
    .card_sel_i   (card_sel_i),
    .ret_val_i    (ret_val),
    .ret_oe_i     (ret_oe),
    .host_io_o    (host_io_o),
    .host_io_oe_o (host_io_oe_o)
  );

  p_mux_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_mode_i && !card_sel_i && !cs_ni && pgm_ni && vcc_good_i[1] && vcc_up_i[1])
      |-> (card_rst_o[1] == host_rst_i[0]));

  p_line1_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_mode_i |-> (!host_io_oe_o[1] && !host_io_o[1]));

  p_host_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_io_oe_o[0] |-> !cs_ni);

  p_pu_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_mode_i |-> pu_en_o[1]);

  p_reset_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rst_ni) && cs_ni) |-> (card_rst_o == '0 && card_c4_o == '0 && card_c8_o == '0));
endmodule

// File: tb/dual_card_contact_ctrl_tb.sv
`timescale 1ns/1ps
module dual_card_contact_ctrl_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, pgm_ni = 1'b1, card_sel_i = 1'b1, mux_mode_i = 1'b0, pu_en_i = 1'b0;
  logic [1:0] host_rst_i = '0, host_io_i = '1, vcc_good_i = '0, vcc_up_i = '0, card_io_i = '1;
  logic host_c4_i = 1'b0, host_c8_i = 1'b0;
  logic [1:0] card_rst_o, card_c4_o, card_c8_o, card_io_o, card_io_oe_o;
  logic [1:0] host_io_o, host_io_oe_o, pu_en_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model state: one stored bit per contact per slot
  bit m_rst[2], m_c4[2], m_c8[2], m_io[2];
  bit in_reset = 1;

  always #4 clk = ~clk;

  dual_card_contact_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .pgm_ni(pgm_ni),
    .card_sel_i(card_sel_i), .mux_mode_i(mux_mode_i), .pu_en_i(pu_en_i),
    .host_rst_i(host_rst_i), .host_io_i(host_io_i), .host_c4_i(host_c4_i),
    .host_c8_i(host_c8_i), .vcc_good_i(vcc_good_i), .vcc_up_i(vcc_up_i),
    .card_io_i(card_io_i), .card_rst_o(card_rst_o), .card_c4_o(card_c4_o),
    .card_c8_o(card_c8_o), .card_io_o(card_io_o), .card_io_oe_o(card_io_oe_o),
    .host_io_o(host_io_o), .host_io_oe_o(host_io_oe_o), .pu_en_o(pu_en_o)
  );

  task automatic cmp(string tag, string what, logic [1:0] act, logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit is_sel(int k);
    return (k == 0) ? card_sel_i : !card_sel_i;
  endfunction

  function automatic bit ok(int k);
    return vcc_good_i[k] && vcc_up_i[k];
  endfunction

  // transparency per slot, per contact group (0 rst, 1 aux, 2 io)
  function automatic bit pass(int k, int grp);
    bit chip = !cs_ni;
    bit lane = !mux_mode_i || is_sel(k);
    case (grp)
      0: return chip && pgm_ni && lane;
      1: return chip && pgm_ni && is_sel(k);
      default: return chip && lane;
    endcase
  endfunction

  function automatic bit rst_src(int k);
    return mux_mode_i ? host_rst_i[0] : host_rst_i[k];
  endfunction

  function automatic bit io_src(int k);
    return mux_mode_i ? host_io_i[0] : host_io_i[k];
  endfunction

  task automatic check_all(string tag);
    logic [1:0] e_rst, e_c4, e_c8, e_io, e_oe, e_hv, e_ho, e_pu, rv, ro;
    for (int k = 0; k < 2; k++) begin
      e_rst[k] = ok(k) && (pass(k, 0) ? rst_src(k) : m_rst[k]);
      e_c4[k]  = ok(k) && (pass(k, 1) ? host_c4_i : m_c4[k]);
      e_c8[k]  = ok(k) && (pass(k, 1) ? host_c8_i : m_c8[k]);
      e_io[k]  = ok(k) && (pass(k, 2) ? io_src(k) : m_io[k]);
      e_oe[k]  = ok(k) && pass(k, 2) && !io_src(k);
      rv[k]    = ok(k) && (pass(k, 2) ? card_io_i[k] : m_io[k]);
      ro[k]    = ok(k) && pass(k, 2) && !card_io_i[k] && io_src(k);
    end
    if (mux_mode_i) begin
      e_hv = {1'b0, card_sel_i ? rv[0] : rv[1]};
      e_ho = {1'b0, card_sel_i ? ro[0] : ro[1]};
    end else begin
      e_hv = rv;
      e_ho = ro;
    end
    e_pu = {pu_en_i | mux_mode_i, pu_en_i};
    cmp(tag, "rst R1", card_rst_o, e_rst);
    cmp(tag, "c4 R4", card_c4_o, e_c4);
    cmp(tag, "c8 R4", card_c8_o, e_c8);
    cmp(tag, "io R5", card_io_o, e_io);
    cmp(tag, "io_oe R5", card_io_oe_o, e_oe);
    cmp(tag, "host_io R6", host_io_o, e_hv);
    cmp(tag, "host_oe R6", host_io_oe_o, e_ho);
    cmp(tag, "pull-up R10", pu_en_o, e_pu);
  endtask

  task automatic model_edge();
    if (in_reset) return;
    for (int k = 0; k < 2; k++) begin
      if (!ok(k)) begin
        m_rst[k] = 0; m_c4[k] = 0; m_c8[k] = 0; m_io[k] = 0;
      end else begin
        if (pass(k, 0)) m_rst[k] = rst_src(k);
        if (pass(k, 1)) begin m_c4[k] = host_c4_i; m_c8[k] = host_c8_i; end
        if (pass(k, 2)) m_io[k] = card_io_i[k];
      end
    end
  endtask

  function automatic bit rnd(int one_in);
    return ($urandom % one_in) == 0;
  endfunction

  task automatic stim(int mode, int cyc);
    host_rst_i = 2'($urandom);
    host_io_i  = 2'($urandom);
    host_c4_i  = 1'($urandom);
    host_c8_i  = 1'($urandom);
    card_io_i  = 2'($urandom);
    vcc_good_i = 2'b11;
    vcc_up_i   = 2'b11;
    case (mode)
      0: begin cs_ni = 1; pgm_ni = 1'($urandom); card_sel_i = 1'($urandom); mux_mode_i = 1'($urandom); end
      1: begin mux_mode_i = 0; cs_ni = 0; pgm_ni = !rnd(8); card_sel_i = 1'($urandom); end
      2: begin mux_mode_i = 0; cs_ni = 1'($urandom); pgm_ni = 1'($urandom); card_sel_i = 1'($urandom); end
      3: begin mux_mode_i = 1'($urandom); cs_ni = rnd(3); pgm_ni = !rnd(3); card_sel_i = 1'($urandom); end
      4: begin mux_mode_i = 1; cs_ni = rnd(4); pgm_ni = !rnd(4); card_sel_i = 1'($urandom); end
      5: begin mux_mode_i = 1'($urandom); cs_ni = rnd(3); pgm_ni = 1; card_sel_i = 1'($urandom); end
      6: begin
        if (rnd(6)) cs_ni = !cs_ni;
        if (rnd(6)) card_sel_i = !card_sel_i;
        if (rnd(8)) pgm_ni = !pgm_ni;
        if (rnd(20)) mux_mode_i = !mux_mode_i;
      end
      7: begin
        mux_mode_i = 1'($urandom); cs_ni = rnd(3); pgm_ni = !rnd(4); card_sel_i = 1'($urandom);
        vcc_good_i = {!rnd(4), !rnd(4)};
        vcc_up_i   = {!rnd(4), !rnd(4)};
      end
      8: begin
        // first half transparent, then supply blips while everything is held
        cs_ni = (cyc % 20) >= 10; pgm_ni = 1; mux_mode_i = 0; card_sel_i = cyc[4];
        if ((cyc % 20) == 14) vcc_good_i = 2'b01;
        if ((cyc % 20) == 16) vcc_up_i   = 2'b10;
      end
      default: begin
        pu_en_i = 1'($urandom); mux_mode_i = 1'($urandom);
        cs_ni = rnd(2); pgm_ni = 1'($urandom); card_sel_i = 1'($urandom);
      end
    endcase
  endtask

  task automatic run(int mode, int n, string tag);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      stim(mode, c);
      #3;
      check_all(tag);
      @(posedge clk);
      model_edge();
    end
  endtask

  initial begin
    // R11: reset with supplies good and chip select high
    vcc_good_i = 2'b11;
    vcc_up_i   = 2'b11;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #3;
      check_all("R11 in reset");
    end
    @(negedge clk);
    rst_ni = 1'b1;
    in_reset = 0;
    run(0, 40, "R11");
    run(1, 300, "R2");
    run(2, 300, "R1");
    run(3, 300, "R4");
    run(4, 300, "R3");
    run(5, 200, "R5");
    run(5, 200, "R6");
    run(6, 400, "R9");
    run(7, 300, "R7");
    run(8, 200, "R8");
    run(9, 200, "R10");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule